// File: doc/BRIEF.md
# Shared-Term Four-Point Integer Transform

This block applies a fixed 4x4 integer matrix to a set of four signed samples and returns four signed results. It needs no multipliers. The matrix has only the gains ±1 and ±2, so every product is either the sample itself or the sample shifted left by one bit. Four butterfly terms are formed first: two sums of mirrored input pairs and two differences of the same pairs. Each output is then one addition or subtraction of two of those terms, with one term doubled for the odd rows. The transform costs eight adders or subtractors and two fixed shifts, where a direct evaluation of the matrix would need twelve additions and four shifts.

The datapath has two register stages. The first holds the butterfly terms and the second holds the outputs. A new input set can be presented on every clock while `in_valid` is high, and results arrive exactly two clocks later with `out_valid` high. No back-pressure exists. Both register stages load only when a valid set reaches them, so the outputs keep their last value while no data flows. Each intermediate grows by just enough bits to stay exact, and the outputs are three bits wider than the inputs. Results are therefore exact for every input combination.

Top module: `shared_term_xform4`

## Requirements
- R1: With the inputs taken as two's-complement signed values, y0 equals x0 + x1 + x2 + x3.
- R2: y1 equals 2*x0 + x1 - x2 - 2*x3.
- R3: y2 equals x0 - x1 - x2 + x3.
- R4: y3 equals x0 - 2*x1 + 2*x2 - x3.
- R5: `out_valid` is high in exactly those cycles that follow, by two rising clock edges, a rising edge at which `in_valid` was sampled high. The outputs in that cycle belong to the set sampled at that edge.
- R6: Input sets presented on consecutive clocks, with no idle cycles between them, each produce a correct result on consecutive clocks.
- R7: Results are exact with no wrap-around for all inputs, including every input at -2^(IN_W-1) or at 2^(IN_W-1)-1. The butterfly terms are IN_W+1 bits wide and the outputs are IN_W+3 bits wide.
- R8: While `rst_n` is low, `out_valid` is 0 and all four outputs are 0.
- R9: When no valid set reaches the output stage, y0..y3 keep their previous values whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Qualifies x0..x3 in this cycle |
| x0 | input | IN_W | Signed input sample 0 |
| x1 | input | IN_W | Signed input sample 1 |
| x2 | input | IN_W | Signed input sample 2 |
| x3 | input | IN_W | Signed input sample 3 |
| out_valid | output | 1 | Qualifies y0..y3, two clocks after the input |
| y0 | output | IN_W+3 | Signed result row 0 |
| y1 | output | IN_W+3 | Signed result row 1 |
| y2 | output | IN_W+3 | Signed result row 2 |
| y3 | output | IN_W+3 | Signed result row 3 |

## Verification
The bench sweeps every combination of eight boundary and interior values on all four inputs and streams them back to back. This targets the full-scale extremes, where a term one bit too narrow, or a missing sign extension before the shift, would wrap y1 or y3 to the wrong sign. A stream with randomly placed idle cycles, followed by a run of idle cycles with inputs that keep changing, checks that results stay paired with their own input set. It also catches a stage that loads without a valid set: such a design would shift results by a cycle or let the outputs drift. Swapped operands in a difference term, or a doubled term placed on the wrong row, show up immediately as mismatches against the matrix that the bench computes itself.

// File: rtl/xfm_pkg.sv
package xfm_pkg;
  // Bit growth of the butterfly terms over the input word.
  localparam int XF_TERM_GROWTH = 1;
  // Bit growth of the outputs over the input word (worst-case gain 6 < 2^3).
  localparam int XF_OUT_GROWTH  = 3;
  // Register stages between input and output.
  localparam int XF_LATENCY     = 2;

  // Indices of the four butterfly terms, as carried in a term vector.
  typedef enum logic [1:0] {
    TERM_SUM_OUTER  = 2'd0,  // x0 + x3
    TERM_SUM_INNER  = 2'd1,  // x1 + x2
    TERM_DIFF_INNER = 2'd2,  // x1 - x2
    TERM_DIFF_OUTER = 2'd3   // x0 - x3
  } term_idx_e;
endpackage

// File: rtl/xfm_valid_pipe.sv
module xfm_valid_pipe #(
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vld_in,
  output logic [DEPTH-1:0] vld_tap
);
  logic [DEPTH-1:0] vld_q;

  generate
    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) vld_q[s] <= 1'b0;
          else        vld_q[s] <= vld_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) vld_q[s] <= 1'b0;
          else        vld_q[s] <= vld_q[s-1];
        end
      end
    end
  endgenerate

  assign vld_tap = vld_q;
endmodule

// File: rtl/xfm_butterfly_stage.sv
module xfm_butterfly_stage #(
  parameter int IN_W = 12,
  parameter int TW   = IN_W + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic signed [IN_W-1:0] a0,
  input  logic signed [IN_W-1:0] a1,
  input  logic signed [IN_W-1:0] a2,
  input  logic signed [IN_W-1:0] a3,
  output logic signed [TW-1:0]   sum_outer,
  output logic signed [TW-1:0]   sum_inner,
  output logic signed [TW-1:0]   diff_inner,
  output logic signed [TW-1:0]   diff_outer
);
  localparam int EXT = TW - IN_W;

  function automatic logic signed [TW-1:0] widen(input logic signed [IN_W-1:0] v);
    return $signed({{EXT{v[IN_W-1]}}, v});
  endfunction

  function automatic logic signed [TW-1:0] bf_add(input logic signed [IN_W-1:0] p,
                                                  input logic signed [IN_W-1:0] q);
    return widen(p) + widen(q);
  endfunction

  function automatic logic signed [TW-1:0] bf_sub(input logic signed [IN_W-1:0] p,
                                                  input logic signed [IN_W-1:0] q);
    return widen(p) - widen(q);
  endfunction

  logic signed [TW-1:0] so_d, si_d, di_d, do_d;

  always_comb begin
    so_d = bf_add(a0, a3);
    si_d = bf_add(a1, a2);
    di_d = bf_sub(a1, a2);
    do_d = bf_sub(a0, a3);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_outer  <= '0;
      sum_inner  <= '0;
      diff_inner <= '0;
      diff_outer <= '0;
    end else if (load) begin
      sum_outer  <= so_d;
      sum_inner  <= si_d;
      diff_inner <= di_d;
      diff_outer <= do_d;
    end
  end
endmodule

// File: rtl/xfm_combine_stage.sv
module xfm_combine_stage #(
  parameter int TW = 13,
  parameter int OW = TW + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic signed [TW-1:0] sum_outer,
  input  logic signed [TW-1:0] sum_inner,
  input  logic signed [TW-1:0] diff_inner,
  input  logic signed [TW-1:0] diff_outer,
  output logic signed [OW-1:0] r0,
  output logic signed [OW-1:0] r1,
  output logic signed [OW-1:0] r2,
  output logic signed [OW-1:0] r3
);
  localparam int EXT = OW - TW;

  function automatic logic signed [OW-1:0] widen(input logic signed [TW-1:0] v);
    return $signed({{EXT{v[TW-1]}}, v});
  endfunction

  // Doubling as a one-bit arithmetic left shift of the widened term.
  function automatic logic signed [OW-1:0] dbl(input logic signed [TW-1:0] v);
    return widen(v) <<< 1;
  endfunction

  logic signed [OW-1:0] r0_d, r1_d, r2_d, r3_d;

  always_comb begin
    r0_d = widen(sum_outer)  + widen(sum_inner);
    r2_d = widen(sum_outer)  - widen(sum_inner);
    r1_d = widen(diff_inner) + dbl(diff_outer);
    r3_d = widen(diff_outer) - dbl(diff_inner);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r0 <= '0;
      r1 <= '0;
      r2 <= '0;
      r3 <= '0;
    end else if (load) begin
      r0 <= r0_d;
      r1 <= r1_d;
      r2 <= r2_d;
      r3 <= r3_d;
    end
  end
endmodule

// File: rtl/shared_term_xform4.sv
module shared_term_xform4
  import xfm_pkg::*;
#(
  parameter int IN_W  = 12,
  parameter int OUT_W = IN_W + XF_OUT_GROWTH
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  x0,
  input  logic signed [IN_W-1:0]  x1,
  input  logic signed [IN_W-1:0]  x2,
  input  logic signed [IN_W-1:0]  x3,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] y0,
  output logic signed [OUT_W-1:0] y1,
  output logic signed [OUT_W-1:0] y2,
  output logic signed [OUT_W-1:0] y3
);
  localparam int TERM_W = IN_W + XF_TERM_GROWTH;
  localparam int LAT    = XF_LATENCY;

  // Named internal events for the checker.
  logic [LAT-1:0]            vld_tap;
  logic                      term_valid;
  logic signed [TERM_W-1:0]  t_sum_outer, t_sum_inner, t_diff_inner, t_diff_outer;

  xfm_valid_pipe #(.DEPTH(LAT)) u_vld (
    .clk     (clk),
    .rst_n   (rst_n),
    .vld_in  (in_valid),
    .vld_tap (vld_tap)
  );

  assign term_valid = vld_tap[0];
  assign out_valid  = vld_tap[LAT-1];

  xfm_butterfly_stage #(.IN_W(IN_W), .TW(TERM_W)) u_bfly (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (in_valid),
    .a0         (x0),
    .a1         (x1),
    .a2         (x2),
    .a3         (x3),
    .sum_outer  (t_sum_outer),
    .sum_inner  (t_sum_inner),
    .diff_inner (t_diff_inner),
    .diff_outer (t_diff_outer)
  );

  xfm_combine_stage #(.TW(TERM_W), .OW(OUT_W)) u_comb (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (term_valid),
    .sum_outer  (t_sum_outer),
    .sum_inner  (t_sum_inner),
    .diff_inner (t_diff_inner),
    .diff_outer (t_diff_outer),
    .r0         (y0),
    .r1         (y1),
    .r2         (y2),
    .r3         (y3)
  );
endmodule

// File: rtl/xfm4_checks.sv
module xfm4_checks #(
  parameter int IN_W  = 12,
  parameter int OUT_W = IN_W + 3,
  parameter int TW    = IN_W + 1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic signed [IN_W-1:0]  x0,
  input logic signed [IN_W-1:0]  x1,
  input logic signed [IN_W-1:0]  x2,
  input logic signed [IN_W-1:0]  x3,
  input logic                    term_valid,
  input logic signed [TW-1:0]    t_sum_outer,
  input logic signed [TW-1:0]    t_diff_outer,
  input logic                    out_valid,
  input logic signed [OUT_W-1:0] y0,
  input logic signed [OUT_W-1:0] y1,
  input logic signed [OUT_W-1:0] y2,
  input logic signed [OUT_W-1:0] y3
);
  // Edges seen since reset release, saturating at 2.
  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              since_rst <= 2'd0;
    else if (since_rst != 2) since_rst <= since_rst + 2'd1;
  end

  assert_valid_delay_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd2) |-> (out_valid == $past(in_valid, 2)));

  assert_row0_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd2 && out_valid) |->
      (int'(y0) == $past(int'(x0) + int'(x1) + int'(x2) + int'(x3), 2)));

  assert_row1_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd2 && out_valid) |->
      (int'(y1) == $past(2 * int'(x0) + int'(x1) - int'(x2) - 2 * int'(x3), 2)));

  assert_row2_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd2 && out_valid) |->
      (int'(y2) == $past(int'(x0) - int'(x1) - int'(x2) + int'(x3), 2)));

  assert_row3_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd2 && out_valid) |->
      (int'(y3) == $past(int'(x0) - 2 * int'(x1) + 2 * int'(x2) - int'(x3), 2)));

  assert_term_exact_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst != 2'd0 && $past(in_valid)) |->
      (int'(t_sum_outer) == $past(int'(x0) + int'(x3)) &&
       int'(t_diff_outer) == $past(int'(x0) - int'(x3))));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst != 2'd0 && !$past(term_valid)) |->
      ($stable(y0) && $stable(y1) && $stable(y2) && $stable(y3)));

  assert_reset_R8: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && y0 == '0 && y1 == '0 && y2 == '0 && y3 == '0));
endmodule

bind shared_term_xform4 xfm4_checks #(.IN_W(IN_W), .OUT_W(OUT_W), .TW(TERM_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .x0           (x0),
  .x1           (x1),
  .x2           (x2),
  .x3           (x3),
  .term_valid   (term_valid),
  .t_sum_outer  (t_sum_outer),
  .t_diff_outer (t_diff_outer),
  .out_valid    (out_valid),
  .y0           (y0),
  .y1           (y1),
  .y2           (y2),
  .y3           (y3)
);

// File: tb/shared_term_xform4_test.sv
module shared_term_xform4_test;
  localparam int IN_W  = 12;
  localparam int OUT_W = IN_W + 3;
  localparam int MAXV  = (1 << (IN_W - 1)) - 1;
  localparam int MINV  = -(1 << (IN_W - 1));

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [IN_W-1:0]  x0 = '0, x1 = '0, x2 = '0, x3 = '0;
  logic                    out_valid;
  logic signed [OUT_W-1:0] y0, y1, y2, y3;

  always #10 clk = ~clk;  // 50 MHz

  shared_term_xform4 #(.IN_W(IN_W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .x0(x0), .x1(x1), .x2(x2), .x3(x3),
    .out_valid(out_valid), .y0(y0), .y1(y1), .y2(y2), .y3(y3)
  );

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  bit finished = 0;

  // Input history, indexed by cycle modulo 4.
  logic hv [4];
  int   ha [4], hb [4], hc [4], hd [4];
  int   ey [4];

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // One clock: drive at the falling edge, compare two rising edges later.
  task automatic step(input logic v, input int a, input int b, input int c,
                      input int d, input string ph);
    int k;
    in_valid = v;
    x0 = a[IN_W-1:0]; x1 = b[IN_W-1:0]; x2 = c[IN_W-1:0]; x3 = d[IN_W-1:0];
    hv[cyc & 3] = v; ha[cyc & 3] = a; hb[cyc & 3] = b; hc[cyc & 3] = c; hd[cyc & 3] = d;
    @(posedge clk);
    @(negedge clk);
    cyc++;
    k = (cyc - 2) & 3;
    // Expected matrix rows; previous values held when no set arrives (R9).
    if (hv[k]) begin
      ey[0] = ha[k] + hb[k] + hc[k] + hd[k];
      ey[1] = 2 * ha[k] + hb[k] - hc[k] - 2 * hd[k];
      ey[2] = ha[k] - hb[k] - hc[k] + hd[k];
      ey[3] = ha[k] - 2 * hb[k] + 2 * hc[k] - hd[k];
    end
    chk({"R5 out_valid ", ph}, int'(out_valid), int'(hv[k]));
    chk({"R1 y0 ", ph}, int'(y0), ey[0]);
    chk({"R2 y1 ", ph}, int'(y1), ey[1]);
    chk({"R3 y2 ", ph}, int'(y2), ey[2]);
    chk({"R4 y3 ", ph}, int'(y3), ey[3]);
  endtask

  int vals [8];

  initial begin
    vals[0] = MINV; vals[1] = MINV + 1; vals[2] = -1000; vals[3] = -1;
    vals[4] = 0;    vals[5] = 1;        vals[6] = 1365;  vals[7] = MAXV;
    for (int i = 0; i < 4; i++) begin
      hv[i] = 1'b0; ha[i] = 0; hb[i] = 0; hc[i] = 0; hd[i] = 0; ey[i] = 0;
    end

    // R8: reset state, with valid inputs applied during reset.
    repeat (3) @(negedge clk);
    in_valid = 1'b1; x0 = 12'sd5; x1 = 12'sd7;
    repeat (2) @(negedge clk);
    chk("R8 out_valid in reset", int'(out_valid), 0);
    chk("R8 y0 in reset", int'(y0), 0);
    chk("R8 y1 in reset", int'(y1), 0);
    chk("R8 y3 in reset", int'(y3), 0);
    in_valid = 1'b0; x0 = '0; x1 = '0;
    rst_n = 1'b1;

    // R6/R7: back-to-back sweep of all 8^4 boundary combinations.
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++)
        for (int c = 0; c < 8; c++)
          for (int d = 0; d < 8; d++)
            step(1'b1, vals[a], vals[b], vals[c], vals[d], "R6 R7 sweep");

    // R7: every input at the same extreme.
    step(1'b1, MINV, MINV, MINV, MINV, "R7 all-min");
    step(1'b1, MAXV, MAXV, MAXV, MAXV, "R7 all-max");
    step(1'b1, MAXV, MINV, MAXV, MINV, "R7 alt");
    step(1'b1, MINV, MAXV, MINV, MAXV, "R7 alt");

    // R9: idle cycles with changing inputs must leave outputs untouched.
    for (int i = 0; i < 8; i++)
      step(1'b0, 17 * i - 60, -33 * i, 100 + i, MINV + i, "R9 idle");

    // R5: random stream with random gaps.
    for (int i = 0; i < 3000; i++) begin
      int r0, r1, r2, r3;
      r0 = int'($urandom_range(MAXV - MINV)) + MINV;
      r1 = int'($urandom_range(MAXV - MINV)) + MINV;
      r2 = int'($urandom_range(MAXV - MINV)) + MINV;
      r3 = int'($urandom_range(MAXV - MINV)) + MINV;
      step(($urandom_range(9) < 7), r0, r1, r2, r3, "R5 R9 gaps");
    end

    // Drain.
    step(1'b0, 0, 0, 0, 0, "R5 drain");
    step(1'b0, 0, 0, 0, 0, "R5 drain");
    step(1'b0, 0, 0, 0, 0, "R5 drain");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule